// File: doc/BRIEF.md
# BCD Countdown Watchdog Alarm Timer

This block is a software watchdog for a register-mapped peripheral. Its timeout is entered as a four-digit BCD value spread over two byte registers on a simple synchronous register bus. The register at the lower address holds hundredths of a second, and the register at the next address holds whole seconds. The timeout range is 00.00 to 99.99 s. An external strobe arrives once per 100 Hz period. Each strobe makes the block count the internal value down by one hundredth, borrowing in BCD. When the count reaches zero, the block raises a watchdog flag and a level interrupt request, and then reloads the entered value so that the alarm repeats.

Software keeps the alarm quiet by touching either register at regular intervals. Any read or write reloads the countdown and clears the flag. An entered value of all zeros turns the watchdog off. The flag is also exported for a command/status register, which can clear it through a separate clear input without restarting the count.

Top module: `bcd_watchdog`

## Requirements
- R1: Address BASE holds the hundredths byte and address BASE+1 holds the seconds byte. Each byte is two BCD digits with the tens digit in bits 7:4. A write stores its byte, and writes may come in either order. A read returns the stored byte on bus_rdata in the same cycle and never the live count.
- R2: Any read or write at either address reloads the countdown with the entered value at that clock edge. When the access is a write, the reload value includes the byte just written. The access also clears wd_flag. An access takes priority over a tick in the same cycle.
- R3: Each tick with no access decrements the count by one hundredth with BCD borrow between digits. When a value of N hundredths is reloaded, the Nth following tick is the timeout. Without a tick the count holds.
- R4: On a timeout, wd_flag is 1 from the next cycle on, and the entered value is reloaded. With no further access, the timeout repeats every N ticks.
- R5: While both registers hold 00, no tick ever sets wd_flag.
- R6: A pulse on flag_clr clears wd_flag without reloading the count. A timeout in the same cycle wins, so the flag stays set.
- R7: wd_irq is a level that equals wd_flag.
- R8: A synchronous reset clears both registers to 00, which disables the watchdog, and clears wd_flag.
- R9: A bus access at any other address stores nothing, does not reload the count and does not clear the flag. bus_rdata reads 0 for such an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_100hz | input | 1 | One-cycle strobe every 10 ms |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| flag_clr | input | 1 | Clears the watchdog flag |
| wd_flag | output | 1 | Watchdog timeout flag |
| wd_irq | output | 1 | Interrupt request, level |

## Verification
On every cycle, the in-line assertions check the following:
- An access clears the flag and loads the count with the entered value.
- The count holds when there is neither a tick nor an access.
- A zero value never produces a timeout.
- The flag rises only after a timeout.
- A clear pulse without a timeout drops the flag.
- Stray addresses leave the registers unchanged.

Only the bench scenarios can show the following:
- The exact tick on which each timeout lands, including values that need a borrow across digits.
- That the alarm repeats on its own.
- That a read of either register returns the entered value.
- That write order does not matter.
- How a clear pulse and a timeout in the same cycle resolve.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef logic [3:0] bcd_digit_t;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned DIGITS_PER_BYTE = 2;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned BASE   = 0,
   parameter int unsigned NREG   = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     bus_sel,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [BYTE_W-1:0]        bus_wdata,
   output logic [BYTE_W-1:0]        bus_rdata,
   output logic                     access,
   output logic [NREG*BYTE_W-1:0]   value_q,
   output logic [NREG*BYTE_W-1:0]   value_next
);
   logic [NREG-1:0] hit;

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_dec
         localparam int unsigned AI = BASE + i;
         assign hit[i] = bus_sel && (bus_addr == AI[ADDR_W-1:0]);
         assign value_next[BYTE_W*i +: BYTE_W] = (hit[i] && bus_wr) ? bus_wdata
                                                : value_q[BYTE_W*i +: BYTE_W];
      end
   endgenerate

   assign access = |hit;

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i] && !bus_wr) bus_rdata = value_q[BYTE_W*i +: BYTE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) value_q <= '0;
      else     value_q <= value_next;
   end

   AST_STRAY_NO_STORE: assert property (@(posedge clk) disable iff (rst)
      !access |=> $stable(value_q)); // R9
endmodule

// File: rtl/bcd_dec.sv
module bcd_dec
   import wdt_pkg::*;
#(
   parameter int unsigned DIGITS = 4
) (
   input  logic [4*DIGITS-1:0] cnt,
   output logic [4*DIGITS-1:0] dec,
   output logic                dec_zero
);
   logic [DIGITS:0] borrow;
   assign borrow[0] = 1'b1;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
         bcd_digit_t d;
         assign d = cnt[4*i +: 4];
         always_comb begin
            if (!borrow[i]) begin
               dec[4*i +: 4] = d;
               borrow[i+1]   = 1'b0;
            end else if (d == 4'd0) begin
               dec[4*i +: 4] = 4'd9;
               borrow[i+1]   = 1'b1;
            end else begin
               dec[4*i +: 4] = d - 4'd1;
               borrow[i+1]   = 1'b0;
            end
         end
      end
   endgenerate

   assign dec_zero = (dec == '0);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
#(
   parameter int unsigned DIGITS = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [4*DIGITS-1:0] load_val,
   input  logic                tick,
   input  logic                enable,
   output logic                timeout
);
   logic [4*DIGITS-1:0] cnt_q;
   logic [4*DIGITS-1:0] cnt_dec;
   logic                dec_zero;

   bcd_dec #(.DIGITS(DIGITS)) u_dec (
      .cnt      (cnt_q),
      .dec      (cnt_dec),
      .dec_zero (dec_zero)
   );

   assign timeout = tick && !load && enable && (dec_zero || cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (tick && enable) cnt_q <= timeout ? load_val : cnt_dec;
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      load |=> cnt_q == $past(load_val)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load && !tick) |=> $stable(cnt_q)); // R3
   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
      !enable |-> !timeout); // R5
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned BASE   = 0,
   parameter int unsigned DIGITS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_100hz,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              flag_clr,
   output logic              wd_flag,
   output logic              wd_irq
);
   localparam int unsigned NREG  = DIGITS / DIGITS_PER_BYTE;
   localparam int unsigned VAL_W = NREG * BYTE_W;

   generate
      if (DIGITS < 2 || (DIGITS % DIGITS_PER_BYTE) != 0) begin : g_bad_digits
         $error("DIGITS must be an even number of at least 2");
      end
      if (BASE + NREG > (1 << ADDR_W)) begin : g_bad_addr
         $error("register window does not fit in ADDR_W");
      end
   endgenerate

   logic             access;
   logic             timeout;
   logic [VAL_W-1:0] value_q;
   logic [VAL_W-1:0] value_next;

   wdt_regs #(.ADDR_W(ADDR_W), .BASE(BASE), .NREG(NREG)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .access     (access),
      .value_q    (value_q),
      .value_next (value_next)
   );

   wdt_counter #(.DIGITS(DIGITS)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (access),
      .load_val (value_next),
      .tick     (tick_100hz),
      .enable   (value_q != '0),
      .timeout  (timeout)
   );

   always_ff @(posedge clk) begin
      if (rst)                      wd_flag <= 1'b0;
      else if (timeout)             wd_flag <= 1'b1;
      else if (access || flag_clr)  wd_flag <= 1'b0;
   end

   assign wd_irq = wd_flag;

   AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (rst)
      access |=> !wd_flag); // R2
   AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (rst)
      timeout |=> wd_flag); // R4
   AST_RISE_NEEDS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
      $rose(wd_flag) |-> $past(timeout)); // R4
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
      (flag_clr && !timeout) |=> !wd_flag); // R6
endmodule

// File: tb/bcd_watchdog_tb.sv
module bcd_watchdog_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 150000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick_100hz = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       flag_clr = 1'b0;
   logic       wd_flag;
   logic       wd_irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   typedef struct {
      int       kind;
      logic [7:0] exp;
      string    tag;
   } exp_item_t;

   exp_item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_watchdog u_dut (
      .clk(clk), .rst(rst), .tick_100hz(tick_100hz),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .flag_clr(flag_clr), .wd_flag(wd_flag), .wd_irq(wd_irq)
   );

   // monitor: compares queued expectations shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
               0: act = {7'd0, wd_flag};
               1: act = {7'd0, wd_irq};
               default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG_CYCLES && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG_CYCLES);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   task automatic push(int kind, logic [7:0] exp, string tag);
      exp_item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic chk_flag(logic exp, string tag);
      push(0, {7'd0, exp}, tag);
      push(1, {7'd0, exp}, {tag, " (R7 irq)"});
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      push(2, exp, tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         tick_100hz = 1'b1;
         @(negedge clk);
         tick_100hz = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8 reset state
      chk_flag(1'b0, "R8 flag after reset");
      rd(4'd0, 8'h00, "R8 hundredths after reset");
      rd(4'd1, 8'h00, "R8 seconds after reset");
      // R5 disabled after reset
      ticks(300);
      chk_flag(1'b0, "R5 zero value never times out");

      // R1 seconds first, then hundredths: 00.05
      wr(4'd1, 8'h00);
      wr(4'd0, 8'h05);
      rd(4'd0, 8'h05, "R1 hundredths readback");
      rd(4'd1, 8'h00, "R1 seconds readback");
      ticks(4);
      chk_flag(1'b0, "R3 no timeout before 5th tick");
      ticks(1);
      chk_flag(1'b1, "R4 timeout on 5th tick");
      @(negedge clk);
      rd(4'd0, 8'h05, "R1 readback is entered value, not count");
      chk_flag(1'b0, "R2 read clears flag");
      // R4 repeat without access
      ticks(5);
      chk_flag(1'b1, "R4 first timeout after reload");
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      chk_flag(1'b0, "R6 flag_clr clears flag");
      ticks(4);
      chk_flag(1'b0, "R6 clear does not reload; R4 no early repeat");
      ticks(1);
      chk_flag(1'b1, "R4 repeated timeout");

      // R2 periodic access keeps it quiet
      rd(4'd1, 8'h00, "R2 read of seconds");
      ticks(3);
      rd(4'd0, 8'h05, "R2 read of hundredths");
      ticks(3);
      chk_flag(1'b0, "R2 reload on read restarts countdown");
      ticks(2);
      chk_flag(1'b1, "R2 timeout 5 ticks after last read");

      // R9 stray address
      wr(4'd5, 8'h33);
      chk_flag(1'b1, "R9 stray write does not clear flag");
      rd(4'd7, 8'h00, "R9 stray read returns 0");
      chk_flag(1'b1, "R9 stray read does not clear flag");
      rd(4'd0, 8'h05, "R9 stray write stored nothing");

      // R3 borrow across one digit: 00.10, hundredths first then seconds
      wr(4'd0, 8'h10);
      wr(4'd1, 8'h00);
      chk_flag(1'b0, "R2 write clears flag");
      ticks(9);
      chk_flag(1'b0, "R3 00.10 before 10th tick");
      ticks(1);
      chk_flag(1'b1, "R3 00.10 times out on 10th tick");

      // R3 borrow into seconds: 01.00
      wr(4'd0, 8'h00);
      wr(4'd1, 8'h01);
      ticks(99);
      chk_flag(1'b0, "R3 01.00 before 100th tick");
      ticks(1);
      chk_flag(1'b1, "R3 01.00 times out on 100th tick");

      // R3 multi-digit: 12.34 = 1234 ticks
      wr(4'd1, 8'h12);
      wr(4'd0, 8'h34);
      ticks(1233);
      chk_flag(1'b0, "R3 12.34 before 1234th tick");
      ticks(1);
      chk_flag(1'b1, "R3 12.34 times out on 1234th tick");

      // R6 clear and timeout in same cycle: 00.01
      wr(4'd1, 8'h00);
      wr(4'd0, 8'h01);
      chk_flag(1'b0, "R2 flag cleared by write");
      tick_100hz = 1'b1; flag_clr = 1'b1;
      @(negedge clk);
      tick_100hz = 1'b0; flag_clr = 1'b0;
      chk_flag(1'b1, "R6 timeout wins over flag_clr");

      // R2 access priority over tick
      tick_100hz = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd0;
      push(2, 8'h01, "R1 read during tick");
      @(negedge clk);
      tick_100hz = 1'b0; bus_sel = 1'b0;
      chk_flag(1'b0, "R2 access beats tick");

      // R5 disable by writing zero
      wr(4'd0, 8'h00);
      ticks(50);
      chk_flag(1'b0, "R5 zero value disables");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule